// File: doc/BRIEF.md
# Per-Branch History Direction Predictor

This block predicts whether a conditional branch will be taken. It keeps a small tagged table of per-branch history registers and one shared table of 2-bit saturating counters. Each history register holds the last K resolved outcomes of one branch, with 1 for taken and 0 for not taken. That history value picks one counter in the shared table, and the counter's upper bit is the prediction. Because the counter table is shared, branches that show the same recent pattern train the same counter.

A fetch stage sends a branch address on the lookup request channel and takes the answer from the response channel. Both channels use valid/ready handshakes. A request is accepted when `lk_valid` and `lk_ready` are both high. The answer appears on the response channel one cycle later. While a response waits with `rsp_ready` low, it holds steady and `lk_ready` stays low. The execute stage reports resolved branches on the update channel. `upd_ready` is tied high, so every cycle with `upd_valid` high is one update.

The history table has SETS sets and WAYS ways. The set index is the low address bits, `pc[IDX_W-1:0]`, and the tag is the remaining upper bits.

Top module: `pag_predictor`

## Requirements
- R1: After reset, every history entry is invalid and every counter holds 01 (weakly not taken). `rsp_valid` is low, and `lk_ready` and `upd_ready` are high.
- R2: A lookup predicts taken exactly when bit 1 of the counter at index H is set. H is the hit entry's history, or all zeros when the lookup misses.
- R3: Each counter is 2 bits wide. It moves up by one on a taken outcome and down by one on a not-taken outcome, and it stays at 11 or 00 when it would pass those limits.
- R4: An update trains the counter selected by the branch's history as it was before this update, using all zeros on a miss. On a miss, the update allocates a way and gives it the history `{0...0, outcome}`.
- R5: On an update hit, the history becomes `{old[K-2:0], outcome}`: the newest outcome enters at bit 0 and bit K-1 is dropped.
- R6: A lookup or update hits when a valid way in set `pc[IDX_W-1:0]` holds tag `pc[PC_W-1:IDX_W]`. At most one way hits, and `rsp_hit` reports the lookup result.
- R7: Allocation in a set uses that set's round-robin pointer. The pointer starts at way 0 and advances after each allocation in the set.
- R8: When a lookup and an update fall in the same cycle, the lookup sees the state from before that update. The update is visible from the next cycle on.
- R9: A lookup is accepted when `lk_valid && lk_ready`, and its response is valid in the next cycle. `lk_ready` equals `!rsp_valid || rsp_ready`. A response with `rsp_ready` low keeps its valid, taken and hit values unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| lk_valid | input | 1 | Lookup request valid |
| lk_ready | output | 1 | Lookup request can be accepted |
| lk_pc | input | PC_W | Branch address to predict |
| rsp_valid | output | 1 | Prediction response valid |
| rsp_ready | input | 1 | Consumer accepts the response |
| rsp_taken | output | 1 | Predicted direction, 1 = taken |
| rsp_hit | output | 1 | Branch had a history entry |
| upd_valid | input | 1 | Resolved branch report valid |
| upd_ready | output | 1 | Always high |
| upd_pc | input | PC_W | Address of the resolved branch |
| upd_taken | input | 1 | Actual outcome, 1 = taken |

## Verification
Prediction and training can land in the same cycle, often for the same branch and the same counter. The bench provokes this on every step of its sweep: it issues a lookup and an update for the same address together, over five branches with distinct outcome patterns. Three of those branches share one set, so lookups and updates also race with replacements. Each response is compared with a reference model in the bench that forms its prediction before applying that cycle's update. A wrong ordering between the two therefore shows up as a wrong direction or a wrong hit flag.

// File: rtl/pag_pkg.sv
package pag_pkg;
  typedef logic [1:0] ctr_t;

  localparam ctr_t CTR_RESET = 2'b01;

  function automatic ctr_t ctr_next(input ctr_t cur, input logic taken);
    if (taken) return (cur == 2'b11) ? cur : cur + 2'b01;
    else       return (cur == 2'b00) ? cur : cur - 2'b01;
  endfunction
endpackage

// File: rtl/pag_tag_match.sv
module pag_tag_match #(
  parameter int SETS  = 4,
  parameter int WAYS  = 2,
  parameter int TAG_W = 10,
  parameter int K     = 4,
  parameter int IDX_W = 2,
  parameter int WAY_W = 1
) (
  input  logic [IDX_W-1:0]                      set_i,
  input  logic [TAG_W-1:0]                      tag_i,
  input  logic [SETS-1:0][WAYS-1:0]             valid_i,
  input  logic [SETS-1:0][WAYS-1:0][TAG_W-1:0]  tags_i,
  input  logic [SETS-1:0][WAYS-1:0][K-1:0]      hist_i,
  output logic [WAYS-1:0]                       hit_vec,
  output logic                                  hit,
  output logic [WAY_W-1:0]                      way,
  output logic [K-1:0]                          hist
);
  always_comb begin
    hit_vec = '0;
    way     = '0;
    hist    = '0;
    for (int w = 0; w < WAYS; w++) begin
      hit_vec[w] = valid_i[set_i][w] && (tags_i[set_i][w] == tag_i);
      if (hit_vec[w]) begin
        way  = WAY_W'(w);
        hist = hist_i[set_i][w];
      end
    end
    hit = |hit_vec;
  end
endmodule

// File: rtl/pag_hist_table.sv
module pag_hist_table #(
  parameter int PC_W = 12,
  parameter int SETS = 4,
  parameter int WAYS = 2,
  parameter int K    = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PC_W-1:0] lk_pc,
  output logic            lk_hit,
  output logic [K-1:0]    lk_hist,
  input  logic            upd_en,
  input  logic [PC_W-1:0] upd_pc,
  input  logic            upd_taken,
  output logic [K-1:0]    upd_hist_old
);
  localparam int IDX_W = $clog2(SETS);
  localparam int TAG_W = PC_W - IDX_W;
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1;

  logic [SETS-1:0][WAYS-1:0]            valid_q;
  logic [SETS-1:0][WAYS-1:0][TAG_W-1:0] tag_q;
  logic [SETS-1:0][WAYS-1:0][K-1:0]     hist_q;
  logic [SETS-1:0][WAY_W-1:0]           rr_q;

  logic [IDX_W-1:0] l_set, u_set;
  logic [WAYS-1:0]  l_vec, u_vec;
  logic [WAY_W-1:0] l_way, u_way;
  logic             u_hit;
  logic [K-1:0]     u_hist;

  assign l_set = lk_pc[IDX_W-1:0];
  assign u_set = upd_pc[IDX_W-1:0];

  pag_tag_match #(.SETS(SETS), .WAYS(WAYS), .TAG_W(TAG_W), .K(K),
                  .IDX_W(IDX_W), .WAY_W(WAY_W)) u_lk_match (
    .set_i(l_set), .tag_i(lk_pc[PC_W-1:IDX_W]), .valid_i(valid_q),
    .tags_i(tag_q), .hist_i(hist_q), .hit_vec(l_vec), .hit(lk_hit),
    .way(l_way), .hist(lk_hist)
  );

  pag_tag_match #(.SETS(SETS), .WAYS(WAYS), .TAG_W(TAG_W), .K(K),
                  .IDX_W(IDX_W), .WAY_W(WAY_W)) u_upd_match (
    .set_i(u_set), .tag_i(upd_pc[PC_W-1:IDX_W]), .valid_i(valid_q),
    .tags_i(tag_q), .hist_i(hist_q), .hit_vec(u_vec), .hit(u_hit),
    .way(u_way), .hist(u_hist)
  );

  assign upd_hist_old = u_hist;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
      tag_q   <= '0;
      hist_q  <= '0;
      rr_q    <= '0;
    end else if (upd_en) begin
      if (u_hit) begin
        hist_q[u_set][u_way] <= {u_hist[K-2:0], upd_taken};
      end else begin
        valid_q[u_set][rr_q[u_set]] <= 1'b1;
        tag_q[u_set][rr_q[u_set]]   <= upd_pc[PC_W-1:IDX_W];
        hist_q[u_set][rr_q[u_set]]  <= {{(K-1){1'b0}}, upd_taken};
        rr_q[u_set] <= (rr_q[u_set] == WAY_W'(WAYS-1)) ? '0 : rr_q[u_set] + 1'b1;
      end
    end
  end

  p_hit_onehot_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(l_vec) && $onehot0(u_vec));

  p_alloc_r4: assert property (@(posedge clk) disable iff (!rst_n)
    upd_en && !u_hit |=> valid_q[$past(u_set)][$past(rr_q[u_set])] &&
      hist_q[$past(u_set)][$past(rr_q[u_set])] == {{(K-1){1'b0}}, $past(upd_taken)});

  p_shift_r5: assert property (@(posedge clk) disable iff (!rst_n)
    upd_en && u_hit |=> hist_q[$past(u_set)][$past(u_way)] ==
      {$past(u_hist[K-2:0]), $past(upd_taken)});

  generate
    if (WAYS > 1) begin : g_rr_chk
      p_rr_adv_r7: assert property (@(posedge clk) disable iff (!rst_n)
        upd_en && !u_hit |=> rr_q[$past(u_set)] != $past(rr_q[u_set]));
    end
  endgenerate
endmodule

// File: rtl/pag_pattern_table.sv
module pag_pattern_table
  import pag_pkg::*;
#(
  parameter int K = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [K-1:0] rd_idx,
  output ctr_t         rd_ctr,
  input  logic         upd_en,
  input  logic [K-1:0] upd_idx,
  input  logic         upd_taken
);
  localparam int ENTRIES = 1 << K;

  ctr_t ctr_q [ENTRIES];

  assign rd_ctr = ctr_q[rd_idx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) ctr_q[i] <= CTR_RESET;
    end else if (upd_en) begin
      ctr_q[upd_idx] <= ctr_next(ctr_q[upd_idx], upd_taken);
    end
  end

  p_sat_hi_r3: assert property (@(posedge clk) disable iff (!rst_n)
    upd_en && upd_taken && ctr_q[upd_idx] == 2'b11 |=> ctr_q[$past(upd_idx)] == 2'b11);

  p_sat_lo_r3: assert property (@(posedge clk) disable iff (!rst_n)
    upd_en && !upd_taken && ctr_q[upd_idx] == 2'b00 |=> ctr_q[$past(upd_idx)] == 2'b00);
endmodule

// File: rtl/pag_predictor.sv
module pag_predictor
  import pag_pkg::*;
#(
  parameter int PC_W = 12,
  parameter int SETS = 4,
  parameter int WAYS = 2,
  parameter int K    = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            lk_valid,
  output logic            lk_ready,
  input  logic [PC_W-1:0] lk_pc,
  output logic            rsp_valid,
  input  logic            rsp_ready,
  output logic            rsp_taken,
  output logic            rsp_hit,
  input  logic            upd_valid,
  output logic            upd_ready,
  input  logic [PC_W-1:0] upd_pc,
  input  logic            upd_taken
);
  logic         lk_fire;
  logic         lk_hit;
  logic [K-1:0] lk_hist;
  logic [K-1:0] upd_hist_old;
  ctr_t         lk_ctr;

  assign upd_ready = 1'b1;
  assign lk_ready  = !rsp_valid || rsp_ready;
  assign lk_fire   = lk_valid && lk_ready;

  pag_hist_table #(.PC_W(PC_W), .SETS(SETS), .WAYS(WAYS), .K(K)) u_hist (
    .clk(clk), .rst_n(rst_n),
    .lk_pc(lk_pc), .lk_hit(lk_hit), .lk_hist(lk_hist),
    .upd_en(upd_valid), .upd_pc(upd_pc), .upd_taken(upd_taken),
    .upd_hist_old(upd_hist_old)
  );

  pag_pattern_table #(.K(K)) u_pt (
    .clk(clk), .rst_n(rst_n),
    .rd_idx(lk_hit ? lk_hist : '0), .rd_ctr(lk_ctr),
    .upd_en(upd_valid), .upd_idx(upd_hist_old), .upd_taken(upd_taken)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_taken <= 1'b0;
      rsp_hit   <= 1'b0;
    end else if (lk_fire) begin
      rsp_valid <= 1'b1;
      rsp_taken <= lk_ctr[1];
      rsp_hit   <= lk_hit;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  p_rsp_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_taken) && $stable(rsp_hit));

  p_fire_rsp_r9: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid && lk_ready |=> rsp_valid);
endmodule

// File: tb/pag_predictor_test.sv
module pag_predictor_test;
  localparam int CLK_PERIOD = 10;
  localparam int PC_W = 12;
  localparam int SETS = 4;
  localparam int WAYS = 2;
  localparam int K    = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic lk_valid = 1'b0, rsp_ready = 1'b1, upd_valid = 1'b0, upd_taken = 1'b0;
  logic [PC_W-1:0] lk_pc = '0, upd_pc = '0;
  logic lk_ready, rsp_valid, rsp_taken, rsp_hit, upd_ready;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pag_predictor #(.PC_W(PC_W), .SETS(SETS), .WAYS(WAYS), .K(K)) uut (
    .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_ready(lk_ready),
    .lk_pc(lk_pc), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_taken(rsp_taken), .rsp_hit(rsp_hit), .upd_valid(upd_valid),
    .upd_ready(upd_ready), .upd_pc(upd_pc), .upd_taken(upd_taken)
  );

  // reference model
  bit        m_valid [SETS][WAYS];
  bit [9:0]  m_tag   [SETS][WAYS];
  bit [3:0]  m_hist  [SETS][WAYS];
  int        m_rr    [SETS];
  int        m_ctr   [16];

  task automatic model_reset();
    for (int s = 0; s < SETS; s++) begin
      m_rr[s] = 0;
      for (int w = 0; w < WAYS; w++) begin
        m_valid[s][w] = 0; m_tag[s][w] = 0; m_hist[s][w] = 0;
      end
    end
    for (int i = 0; i < 16; i++) m_ctr[i] = 1;
  endtask

  task automatic model_find(input logic [PC_W-1:0] pc, output bit hit,
                            output int way, output bit [3:0] h);
    int s = int'(pc[1:0]);
    hit = 0; way = 0; h = 0;
    for (int w = 0; w < WAYS; w++)
      if (m_valid[s][w] && m_tag[s][w] == pc[11:2]) begin
        hit = 1; way = w; h = m_hist[s][w];
      end
  endtask

  task automatic model_pred(input logic [PC_W-1:0] pc, output bit t, output bit hit);
    int way; bit [3:0] h;
    model_find(pc, hit, way, h);
    t = (m_ctr[h] >= 2);
  endtask

  task automatic model_upd(input logic [PC_W-1:0] pc, input bit t);
    int way; bit hit; bit [3:0] h;
    int s = int'(pc[1:0]);
    model_find(pc, hit, way, h);
    if (t) m_ctr[h] = (m_ctr[h] == 3) ? 3 : m_ctr[h] + 1;
    else   m_ctr[h] = (m_ctr[h] == 0) ? 0 : m_ctr[h] - 1;
    if (hit) m_hist[s][way] = {h[2:0], t};
    else begin
      m_valid[s][m_rr[s]] = 1; m_tag[s][m_rr[s]] = pc[11:2];
      m_hist[s][m_rr[s]] = {3'b000, t};
      m_rr[s] = (m_rr[s] + 1) % WAYS;
    end
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // one cycle: optional lookup and update together
  task automatic step(input bit lv, input logic [PC_W-1:0] lpc, input bit uv,
                      input logic [PC_W-1:0] upc, input bit ut, input string req);
    bit et, eh;
    @(negedge clk);
    lk_valid = lv; lk_pc = lpc; upd_valid = uv; upd_pc = upc; upd_taken = ut;
    rsp_ready = 1'b1;
    if (lv) model_pred(lpc, et, eh);
    @(posedge clk);
    if (uv) model_upd(upc, ut);
    #1;
    if (lv) chk(rsp_valid && rsp_taken == et && rsp_hit == eh, req,
                {rsp_valid, rsp_hit, rsp_taken}, {1'b1, eh, et});
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [PC_W-1:0] pcs [5];
    int cnt [5];
    logic [15:0] lfsr;
    bit held_t, held_h;
    pcs[0] = 12'h004; pcs[1] = 12'h104; pcs[2] = 12'h208;
    pcs[3] = 12'h031; pcs[4] = 12'h0E2;
    for (int i = 0; i < 5; i++) cnt[i] = 0;
    model_reset();
    repeat (3) @(posedge clk);
    #1;
    // R1: reset state at the ports
    chk(!rsp_valid && lk_ready && upd_ready, "R1", {rsp_valid, lk_ready, upd_ready}, 3'b011);
    @(negedge clk); rst_n = 1'b1;

    // R1/R2: cold lookup misses and predicts not taken
    step(1, 12'h004, 0, 0, 0, "R1");
    // R4/R5: allocation then history growth
    step(0, 0, 1, 12'h004, 1, "R4");
    step(1, 12'h004, 1, 12'h004, 1, "R5");
    step(1, 12'h004, 0, 0, 0, "R6");
    // R3: drive counter at history 1111 into saturation and back
    for (int i = 0; i < 8; i++) step(1, 12'h004, 1, 12'h004, 1, "R3");
    step(1, 12'h004, 1, 12'h004, 0, "R3");
    for (int i = 0; i < 4; i++) step(1, 12'h004, 1, 12'h004, 1, "R3");
    for (int i = 0; i < 6; i++) step(1, 12'h031, 1, 12'h031, 0, "R3");
    // R7: three branches in set 0 rotate through two ways
    step(0, 0, 1, 12'h104, 1, "R7");
    step(1, 12'h004, 1, 12'h208, 0, "R7");
    step(1, 12'h104, 0, 0, 0, "R7");
    step(1, 12'h208, 0, 0, 0, "R7");

    // R9: back-pressure holds the response
    @(negedge clk);
    lk_valid = 1; lk_pc = 12'h208; upd_valid = 0; rsp_ready = 0;
    model_pred(12'h208, held_t, held_h);
    @(posedge clk); #1;
    @(negedge clk);
    chk(rsp_valid && !lk_ready, "R9", {rsp_valid, lk_ready}, 2'b10);
    lk_pc = 12'h0E2; upd_valid = 1; upd_pc = 12'h208; upd_taken = 1;
    for (int i = 0; i < 3; i++) begin
      @(posedge clk); model_upd(12'h208, 1); #1;
      chk(rsp_valid && rsp_taken == held_t && rsp_hit == held_h, "R9",
          {rsp_valid, rsp_hit, rsp_taken}, {1'b1, held_h, held_t});
    end
    @(negedge clk);
    lk_valid = 0; upd_valid = 0; rsp_ready = 1;
    @(posedge clk); #1;
    chk(!rsp_valid, "R9", rsp_valid, 0);

    // R8: sweep with same-cycle lookup and update of the same branch
    lfsr = 16'hACE1;
    for (int n = 0; n < 800; n++) begin
      int b;
      bit t;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      b = int'(lfsr[7:0]) % 5;
      case (b)
        0: t = 1;
        1: t = cnt[1][0];
        2: t = (cnt[2] % 3) != 2;
        3: t = 0;
        default: t = lfsr[9];
      endcase
      cnt[b]++;
      step(1, pcs[b], 1, pcs[b], t, (n % 2 == 0) ? "R8" : "R2");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule